// File: doc/BRIEF.md
# Linked Command Block Execution Unit

This unit walks a chain of command blocks held in system memory. Each block takes two 32-bit words. The word at the block address carries the block's status in its low half and its command in its high half. The word four bytes further on holds the address of the next block. After a start pulse the unit reads both words and decodes the flag bits and the 3-bit opcode of the command. It then runs a placeholder action for that opcode and writes a completion status back into the block's first word.

Flag bits in each command decide what happens next:

- The unit may raise a one-cycle completion interrupt.
- It may stop and go idle at the end of the list.
- It may pause in a suspended state until it is started again.
- Otherwise it moves on to the block named by the link word.

The unit's own 2-bit state occupies the top two bits of an 8-bit status register. Host logic owns the lower six bits of that register. Memory is reached through one read port and one write port, each with a request/ready handshake.

Top module: `cbu_top`

## Requirements
- R1: After reset the status register reads 0x00 (unit idle), no read or write request is raised and the interrupt is low.
- R2: Unit state codes in status bits 7:6 are idle=0, suspended=1 and active=2. A start pulse given while idle or suspended sets the state to active and begins a fetch at the start address. A start pulse given while active is ignored and leaves the block at its address untouched.
- R3: The word at block address A holds the status in bits 15:0 and the command in bits 31:16. The word at A+4 holds the link. Command bits are: 15 end-of-list, 14 suspend, 13 interrupt, 4 no-CRC, 3 flexible mode, and 2:0 opcode.
- R4: A read request holds its address stable until rd_ready is seen high.
- R5: The writeback is one word at A. Bits 31:16 are the command unchanged, including the no-CRC and flexible-mode bits. Bits 15:0 are the old status ORed with 0x8000, and ORed with 0x2000 as well when the action succeeded.
- R6: Opcode 0 succeeds with no action wait. Opcodes 1 to 4 succeed after an action stub of ACT_LAT cycles (default 4), so their writeback comes exactly ACT_LAT cycles later than for opcode 0. Opcodes 5 to 7 complete with bit 13 clear.
- R7: When the interrupt bit is set, irq pulses high for one cycle, in the cycle right after the writeback is accepted. When the bit is clear there is no pulse.
- R8: With end-of-list set the unit returns to idle after the writeback. End-of-list takes precedence over suspend.
- R9: With only suspend set the unit goes to suspended after the writeback and fetches nothing more until a new start pulse.
- R10: With neither end-of-list nor suspend set, the unit fetches the block at the link address next, staying active.
- R11: A host write loads status bits 5:0. Unit state updates never change bits 5:0, and host writes never change bits 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse |
| start_addr | input | 32 | First block address for a start |
| host_wr | input | 1 | Host write strobe for status bits 5:0 |
| host_wdata | input | 6 | Host value for status bits 5:0 |
| status | output | 8 | Unit state in 7:6, host bits in 5:0 |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | 32 | Memory read byte address |
| rd_ready | input | 1 | Read accepted; rd_data valid this cycle |
| rd_data | input | 32 | Memory read data |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | 32 | Memory write byte address |
| wr_data | output | 32 | Memory write data |
| wr_ready | input | 1 | Write accepted this cycle |
| irq | output | 1 | Command-complete interrupt pulse |

## Verification
The hardest case to reach is a start pulse that arrives while a chain is still active. It must be dropped without disturbing the block being run. The stimulus reaches it by running a slow opcode with memory wait states and pulsing start at a second, prepared block address partway through. It then checks that this second block's memory word is unchanged once the unit goes idle. Suspension with host-owned status bits set, and the interrupt landing one cycle after a stalled writeback, are reached with multi-block chains built in the bench memory model.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int HALF_W   = DATA_W / 2;
    localparam int LINK_OFS = 4;
    localparam int HOST_W   = 6;

    typedef enum logic [1:0] {
        U_IDLE    = 2'd0,
        U_SUSPEND = 2'd1,
        U_ACTIVE  = 2'd2
    } ustate_e;

    typedef enum logic [2:0] {
        S_WAIT,
        S_RD0,
        S_RD1,
        S_EXEC,
        S_WR
    } fsm_e;

    typedef struct packed {
        logic       last;
        logic       susp;
        logic       intr;
        logic [7:0] rsvd;
        logic       nocrc;
        logic       flex;
        logic [2:0] op;
    } cmd_t;

    function automatic logic [HALF_W-1:0] done_status(logic [HALF_W-1:0] old, logic ok);
        return old | 16'h8000 | (ok ? 16'h2000 : 16'h0000);
    endfunction

endpackage

// File: rtl/cbu_decode.sv
module cbu_decode
    import cbu_pkg::*;
#(
    parameter logic [7:0] KNOWN_OPS = 8'h1F
) (
    input  logic [2:0] op,
    output logic       known,
    output logic       needs_wait
);
    always_comb begin
        known      = KNOWN_OPS[op];
        needs_wait = KNOWN_OPS[op] && (op != 3'd0);
    end
endmodule

// File: rtl/cbu_action.sv
module cbu_action #(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic done
);
    localparam int CW = (LAT > 1) ? $clog2(LAT) : 1;

    logic          busy_q;
    logic [CW-1:0] cnt_q;

    assign done = busy_q && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (go) begin
            busy_q <= 1'b1;
            cnt_q  <= CW'(LAT - 1);
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R6: the stub is never restarted while it is counting
    a_r6_go_when_free: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy_q);
endmodule

// File: rtl/cbu_seq.sv
module cbu_seq
    import cbu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    output ustate_e           ust,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              irq,
    output logic [2:0]        op_code,
    input  logic              op_known,
    input  logic              op_wait,
    output logic              act_go,
    input  logic              act_done
);
    fsm_e              st_q;
    ustate_e           ust_q;
    logic [ADDR_W-1:0] cur_q;
    logic [ADDR_W-1:0] link_q;
    cmd_t              cmd_q;
    logic [HALF_W-1:0] sts_q;
    logic              ok_q;
    logic              irq_q;
    logic              rd_fire;
    logic              wr_fire;

    assign rd_fire = rd_req && rd_ready;
    assign wr_fire = wr_req && wr_ready;
    assign ust     = ust_q;
    assign irq     = irq_q;
    assign op_code = cmd_q.op;

    always_comb begin
        rd_req  = (st_q == S_RD0) || (st_q == S_RD1);
        rd_addr = (st_q == S_RD1) ? cur_q + ADDR_W'(LINK_OFS) : cur_q;
        wr_req  = (st_q == S_WR);
        wr_addr = cur_q;
        wr_data = {cmd_q, done_status(sts_q, ok_q)};
        act_go  = (st_q == S_RD1) && rd_fire && op_wait;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_WAIT;
            ust_q  <= U_IDLE;
            cur_q  <= '0;
            link_q <= '0;
            cmd_q  <= '0;
            sts_q  <= '0;
            ok_q   <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (st_q)
                S_WAIT: if (start) begin
                    cur_q <= start_addr;
                    ust_q <= U_ACTIVE;
                    st_q  <= S_RD0;
                end
                S_RD0: if (rd_fire) begin
                    cmd_q <= cmd_t'(rd_data[DATA_W-1:HALF_W]);
                    sts_q <= rd_data[HALF_W-1:0];
                    st_q  <= S_RD1;
                end
                S_RD1: if (rd_fire) begin
                    link_q <= rd_data;
                    ok_q   <= op_known;
                    st_q   <= op_wait ? S_EXEC : S_WR;
                end
                S_EXEC: if (act_done) begin
                    st_q <= S_WR;
                end
                S_WR: if (wr_fire) begin
                    irq_q <= cmd_q.intr;
                    if (cmd_q.last) begin
                        ust_q <= U_IDLE;
                        st_q  <= S_WAIT;
                    end else if (cmd_q.susp) begin
                        ust_q <= U_SUSPEND;
                        st_q  <= S_WAIT;
                    end else begin
                        cur_q <= link_q;
                        st_q  <= S_RD0;
                    end
                end
                default: st_q <= S_WAIT;
            endcase
        end
    end

    // R4: read address held until accepted
    a_r4_rd_hold: assert property (@(posedge clk) disable iff (rst)
        rd_req && !rd_ready |=> rd_req && $stable(rd_addr));

    // R7: interrupt only right after an accepted writeback
    a_r7_irq_after_wr: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(wr_fire));

    // R6: a no-operation always writes back with OK
    a_r6_nop_ok: assert property (@(posedge clk) disable iff (rst)
        wr_req && (wr_data[18:16] == 3'd0) |-> wr_data[13]);

    // R5: one memory access at a time, every writeback marks completion
    a_r5_wr_complete: assert property (@(posedge clk) disable iff (rst)
        wr_req |-> !rd_req && wr_data[15]);

    // R2: only legal state codes, and never active while waiting for a start
    a_r2_state_legal: assert property (@(posedge clk) disable iff (rst)
        (ust_q != 2'd3) && ((st_q == S_WAIT) -> (ust_q != U_ACTIVE)));
endmodule

// File: rtl/cbu_top.sv
module cbu_top
    import cbu_pkg::*;
#(
    parameter int         ACT_LAT   = 4,
    parameter logic [7:0] KNOWN_OPS = 8'h1F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              host_wr,
    input  logic [HOST_W-1:0] host_wdata,
    output logic [7:0]        status,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic              irq
);
    logic [HOST_W-1:0] host_q;
    ustate_e           ust;
    logic [2:0]        op_code;
    logic              op_known;
    logic              op_wait;
    logic              act_go;
    logic              act_done;

    always_ff @(posedge clk) begin
        if (rst)          host_q <= '0;
        else if (host_wr) host_q <= host_wdata;
    end

    assign status = {ust, host_q};

    cbu_decode #(.KNOWN_OPS(KNOWN_OPS)) u_dec (
        .op(op_code), .known(op_known), .needs_wait(op_wait)
    );

    cbu_action #(.LAT(ACT_LAT)) u_act (
        .clk(clk), .rst(rst), .go(act_go), .done(act_done)
    );

    cbu_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .ust(ust),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .irq(irq), .op_code(op_code), .op_known(op_known), .op_wait(op_wait),
        .act_go(act_go), .act_done(act_done)
    );

    // R11: host bits change only through a host write
    a_r11_host_bits: assert property (@(posedge clk) disable iff (rst)
        !$past(host_wr) |-> status[5:0] == $past(status[5:0]));
endmodule

// File: tb/cbu_top_tb_top.sv
module cbu_top_tb_top;
    localparam int LAT = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        host_wr = 1'b0;
    logic [5:0]  host_wdata = '0;
    logic [7:0]  status;
    logic        rd_req, wr_req, irq;
    logic [31:0] rd_addr, wr_addr, wr_data, rd_data;
    logic        rd_ready, wr_ready;

    logic [31:0] mem [256];
    logic        tb_we = 1'b0;
    logic [31:0] tb_waddr = '0;
    logic [31:0] tb_wdata = '0;
    logic        stall_en = 1'b0;
    logic        phase = 1'b0;
    int          cyc = 0;
    int          last_wr = 0;
    int          last_gap = 0;
    int          irq_cnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    cbu_top dut_i (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .host_wr(host_wr), .host_wdata(host_wdata), .status(status),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
        .irq(irq)
    );

    assign rd_ready = !stall_en || phase;
    assign wr_ready = !stall_en || phase;
    assign rd_data  = mem[rd_addr[9:2]];

    always @(negedge clk) phase <= ~phase;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tb_we) mem[tb_waddr[9:2]] <= tb_wdata;
        else if (wr_req && wr_ready) begin
            mem[wr_addr[9:2]] <= wr_data;
        end
        if (wr_req && wr_ready) last_wr <= cyc;
        if (irq) begin
            irq_cnt  <= irq_cnt + 1;
            last_gap <= cyc - last_wr;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_waddr = a; tb_wdata = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic kick(input logic [31:0] a);
        @(negedge clk);
        start = 1'b1; start_addr = a;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_stop();
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (status[7:6] != 2'd2) break;
        end
        repeat (2) @(negedge clk);
    endtask

    // {command, old status, expected status, expected irq}
    localparam logic [48:0] VEC [8] = '{
        {16'h8000, 16'h0000, 16'hA000, 1'b0},
        {16'hA001, 16'h0000, 16'hA000, 1'b1},
        {16'h8005, 16'h0012, 16'h8012, 1'b0},
        {16'hA007, 16'h0100, 16'h8100, 1'b1},
        {16'h8018, 16'h00FF, 16'hA0FF, 1'b0},
        {16'h8004, 16'h2000, 16'hA000, 1'b0},
        {16'h8006, 16'h0001, 16'h8001, 1'b0},
        {16'hE002, 16'h0000, 16'hA000, 1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int t0, d_nop, d_op1, ic;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(status == 8'h00, "R1 status", {24'h0, status}, 32'h0);
        check(!rd_req && !wr_req, "R1 requests", {30'h0, rd_req, wr_req}, 32'h0);
        check(!irq, "R1 irq", {31'h0, irq}, 32'h0);

        // vector table: single blocks at 0x200 with end-of-list (R3 R5 R6 R7 R8)
        for (int v = 0; v < 8; v++) begin
            poke(32'h200, {VEC[v][48:33], VEC[v][32:17]});
            poke(32'h204, 32'h0);
            stall_en = v[0];
            ic = irq_cnt;
            kick(32'h200);
            wait_stop();
            check(mem[128] == {VEC[v][48:33], VEC[v][16:1]}, "R5 R6 writeback word", mem[128], {VEC[v][48:33], VEC[v][16:1]});
            check(irq_cnt - ic == int'(VEC[v][0]), "R7 irq count", irq_cnt - ic, {31'h0, VEC[v][0]});
            if (VEC[v][0]) check(last_gap == 1, "R7 irq one cycle after write", last_gap, 1);
            check(status[7:6] == 2'd0, "R8 idle after end-of-list", {30'h0, status[7:6]}, 0);
        end

        // R6 latency of stub versus no-operation
        stall_en = 1'b0;
        poke(32'h200, 32'h8000_0000);
        @(negedge clk); t0 = cyc; kick(32'h200); wait_stop(); d_nop = last_wr - t0;
        poke(32'h200, 32'h8001_0000);
        @(negedge clk); t0 = cyc; kick(32'h200); wait_stop(); d_op1 = last_wr - t0;
        check(d_op1 - d_nop == LAT, "R6 stub latency", d_op1 - d_nop, LAT);

        // R10 chain through links, with memory stalls
        stall_en = 1'b1;
        poke(32'h000, 32'h0001_0000); poke(32'h004, 32'h40);
        poke(32'h040, 32'h2000_0000); poke(32'h044, 32'h80);
        poke(32'h080, 32'h8003_0000); poke(32'h084, 32'h0);
        ic = irq_cnt;
        kick(32'h000);
        repeat (2) @(negedge clk);
        check(status[7:6] == 2'd2, "R2 active while running", {30'h0, status[7:6]}, 2);
        wait_stop();
        check(mem[0] == 32'h0001_A000, "R10 first block", mem[0], 32'h0001_A000);
        check(mem[16] == 32'h2000_A000, "R10 second block", mem[16], 32'h2000_A000);
        check(mem[32] == 32'h8003_A000, "R10 third block", mem[32], 32'h8003_A000);
        check(irq_cnt - ic == 1, "R7 chain irq count", irq_cnt - ic, 1);
        check(status[7:6] == 2'd0, "R8 chain idle", {30'h0, status[7:6]}, 0);

        // R9 suspend, then restart from suspended
        poke(32'h100, 32'h4000_0000); poke(32'h104, 32'h140);
        poke(32'h140, 32'h8000_0000); poke(32'h144, 32'h0);
        kick(32'h100);
        wait_stop();
        check(status[7:6] == 2'd1, "R9 suspended", {30'h0, status[7:6]}, 1);
        check(mem[64] == 32'h4000_A000, "R9 suspend block written", mem[64], 32'h4000_A000);
        check(mem[80] == 32'h8000_0000, "R9 no fetch past suspend", mem[80], 32'h8000_0000);
        kick(32'h140);
        wait_stop();
        check(mem[80] == 32'h8000_A000, "R2 restart from suspended", mem[80], 32'h8000_A000);
        check(status[7:6] == 2'd0, "R8 idle after restart", {30'h0, status[7:6]}, 0);

        // R2 start ignored while active
        poke(32'h300, 32'h8001_0000); poke(32'h304, 32'h0);
        poke(32'h380, 32'h8000_0000); poke(32'h384, 32'h0);
        kick(32'h300);
        repeat (3) @(negedge clk);
        kick(32'h380);
        wait_stop();
        check(mem[192] == 32'h8001_A000, "R2 running block done", mem[192], 32'h8001_A000);
        check(mem[224] == 32'h8000_0000, "R2 start while active ignored", mem[224], 32'h8000_0000);

        // R11 host bits versus unit state
        @(negedge clk); host_wr = 1'b1; host_wdata = 6'h3F;
        @(negedge clk); host_wr = 1'b0;
        check(status == 8'h3F, "R11 host write keeps state", {24'h0, status}, 32'h3F);
        poke(32'h180, 32'h4000_0000); poke(32'h184, 32'h0);
        kick(32'h180);
        wait_stop();
        check(status == 8'h7F, "R11 unit update keeps host bits", {24'h0, status}, 32'h7F);
        @(negedge clk); host_wr = 1'b1; host_wdata = 6'h00;
        @(negedge clk); host_wr = 1'b0;
        check(status == 8'h40, "R11 host clear keeps suspended", {24'h0, status}, 32'h40);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule